// File: doc/BRIEF.md
# Boundary Scan Output Cell Chain

This block is a row of scan cells that sits between the core's output signals and the pads. In normal operation each cell passes the core value straight through to its pad. In test mode a tester can do three more things. It can sample what the core is driving. It can move that sample out one bit per cycle through a serial path. It can then load fresh values the same way and apply them to the pads as a group.

Each cell holds two flops. The first flop is the sample/shift stage. It takes either the cell's core input or the previous cell's first flop. The second flop is the hold stage. It takes a copy of the first flop only on an explicit update strobe. Because of this split, the pads stay still while a new pattern moves through the chain. A single capture/shift enable stands in for a dedicated scan clock, and the shift select picks which source feeds the first stage. Cell 0 is nearest the serial input, and cell CELLS-1 drives the serial output.

Top module: `bscan_chain`

## Requirements
- R1: When testMode is 0, padOut equals coreIn in the same cycle, bit for bit, whatever the flop contents are.
- R2: When testMode is 1, padOut[i] equals the hold-stage flop of cell i.
- R3: On a clock edge with drClockEn=1 and shiftSel=1, the sample stage of cell 0 takes scanIn, and the sample stage of cell i (i>0) takes the old sample stage of cell i-1.
- R4: On a clock edge with drClockEn=1 and shiftSel=0, the sample stage of every cell i takes coreIn[i].
- R5: On a clock edge with drClockEn=0, every sample stage keeps its value, whatever shiftSel and scanIn are.
- R6: On a clock edge with updateEn=1, every hold stage takes the pre-edge value of its cell's sample stage. With updateEn=0, the hold stages keep their value, including during a shift or capture.
- R7: When updateEn and a shift or capture fall on the same edge, the hold stages get the sample values from before that edge, not the newly loaded ones.
- R8: scanOut equals the sample stage of cell CELLS-1 at all times.
- R9: A clock edge with rst=1 clears every sample and hold stage to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| coreIn | input | CELLS | Values from the core logic, one bit per cell |
| padOut | output | CELLS | Values driven toward the pads |
| scanIn | input | 1 | Serial data into cell 0 |
| scanOut | output | 1 | Serial data from cell CELLS-1 |
| shiftSel | input | 1 | 1 = shift from the serial path, 0 = capture coreIn |
| drClockEn | input | 1 | Enables the sample stage to load |
| updateEn | input | 1 | One-cycle strobe that copies the sample stages to the hold stages |
| testMode | input | 1 | 1 = pads take the hold stages, 0 = pads take coreIn |

## Verification
An update and a shift, or an update and a capture, can fall on the same edge. The bench provokes both cases after it has loaded a known pattern into the sample stages. It raises updateEn together with drClockEn, once with shiftSel at 1 and once with shiftSel at 0. With testMode at 1, padOut must then show the old sample pattern and not the new one. Next the sample stages are shifted out, and scanOut must show the newly shifted or captured values.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef struct packed {
    logic loadFunc;    // sample stage loads the core input
    logic loadSerial;  // sample stage loads the neighbour's sample
    logic copyHold;    // hold stage loads the sample stage
    logic driveHold;   // pad takes the hold stage
  } bsStrobes_t;

endpackage

// File: rtl/bscan_ctrl.sv
module bscan_ctrl
  import bscan_pkg::*;
(
  input  logic       shiftSel,
  input  logic       drClockEn,
  input  logic       updateEn,
  input  logic       testMode,
  output bsStrobes_t strobes
);

  always_comb begin
    strobes.loadFunc   = drClockEn & ~shiftSel;
    strobes.loadSerial = drClockEn & shiftSel;
    strobes.copyHold   = updateEn;
    strobes.driveHold  = testMode;
  end

endmodule

// File: rtl/bscan_cell.sv
module bscan_cell
  import bscan_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  bsStrobes_t strobes,
  input  logic       funcIn,
  input  logic       serIn,
  output logic       sampleQ,
  output logic       holdQ,
  output logic       cellOut
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sampleQ <= 1'b0;
    end else if (strobes.loadSerial) begin
      sampleQ <= serIn;
    end else if (strobes.loadFunc) begin
      sampleQ <= funcIn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdQ <= 1'b0;
    end else if (strobes.copyHold) begin
      holdQ <= sampleQ;
    end
  end

  assign cellOut = strobes.driveHold ? holdQ : funcIn;

endmodule

// File: rtl/bscan_dp.sv
module bscan_dp
  import bscan_pkg::*;
#(
  parameter int CELLS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  bsStrobes_t       strobes,
  input  logic [CELLS-1:0] coreIn,
  input  logic             scanIn,
  output logic [CELLS-1:0] padOut,
  output logic [CELLS-1:0] stageA,
  output logic [CELLS-1:0] stageB,
  output logic             scanOut
);

  localparam int LAST = CELLS - 1;

  logic [CELLS-1:0] serialFeed;

  assign serialFeed = {stageA[CELLS-2:0], scanIn};

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    bscan_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .strobes (strobes),
      .funcIn  (coreIn[i]),
      .serIn   (serialFeed[i]),
      .sampleQ (stageA[i]),
      .holdQ   (stageB[i]),
      .cellOut (padOut[i])
    );
  end

  assign scanOut = stageA[LAST];

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int CELLS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CELLS-1:0] coreIn,
  output logic [CELLS-1:0] padOut,
  input  logic             scanIn,
  output logic             scanOut,
  input  logic             shiftSel,
  input  logic             drClockEn,
  input  logic             updateEn,
  input  logic             testMode
);

  bsStrobes_t       strobes;
  logic [CELLS-1:0] stageA;
  logic [CELLS-1:0] stageB;

  bscan_ctrl u_ctrl (
    .shiftSel  (shiftSel),
    .drClockEn (drClockEn),
    .updateEn  (updateEn),
    .testMode  (testMode),
    .strobes   (strobes)
  );

  bscan_dp #(.CELLS(CELLS)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .coreIn  (coreIn),
    .scanIn  (scanIn),
    .padOut  (padOut),
    .stageA  (stageA),
    .stageB  (stageB),
    .scanOut (scanOut)
  );

endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
  parameter int CELLS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [CELLS-1:0] coreIn,
  input logic [CELLS-1:0] padOut,
  input logic             scanIn,
  input logic             scanOut,
  input logic             shiftSel,
  input logic             drClockEn,
  input logic             updateEn,
  input logic             testMode,
  input logic [CELLS-1:0] stageA,
  input logic [CELLS-1:0] stageB
);

  p_passthru_r1: assert property (@(posedge clk) disable iff (rst)
    !testMode |-> padOut == coreIn);

  p_drive_hold_r2: assert property (@(posedge clk) disable iff (rst)
    testMode |-> padOut == stageB);

  p_shift_r3: assert property (@(posedge clk) disable iff (rst)
    (drClockEn && shiftSel) |=>
      stageA == {$past(stageA[CELLS-2:0]), $past(scanIn)});

  p_capture_r4: assert property (@(posedge clk) disable iff (rst)
    (drClockEn && !shiftSel) |=> stageA == $past(coreIn));

  p_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !drClockEn |=> $stable(stageA));

  p_update_r6: assert property (@(posedge clk) disable iff (rst)
    updateEn |=> stageB == $past(stageA));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !updateEn |=> $stable(stageB));

  // R7: update on a shift/capture edge takes the pre-edge sample
  p_same_edge_r7: assert property (@(posedge clk) disable iff (rst)
    (updateEn && drClockEn) |=> stageB == $past(stageA));

  p_scanout_r8: assert property (@(posedge clk) disable iff (rst)
    scanOut == stageA[CELLS-1]);

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (stageA == '0) && (stageB == '0));

endmodule

bind bscan_chain bscan_chain_chk #(.CELLS(CELLS)) u_chk (.*);

// File: tb/tb_bscan_chain.sv
`timescale 1ns/1ps
module tb_bscan_chain;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] coreIn = '0;
  logic [N-1:0] padOut;
  logic         scanIn = 1'b0;
  logic         scanOut;
  logic         shiftSel = 1'b0;
  logic         drClockEn = 1'b0;
  logic         updateEn = 1'b0;
  logic         testMode = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench's own view of the cell stages, built from the requirements
  logic [N-1:0] mA = '0;
  logic [N-1:0] mB = '0;

  always #2.5 clk = ~clk;

  bscan_chain #(.CELLS(N)) dut (
    .clk(clk), .rst(rst), .coreIn(coreIn), .padOut(padOut),
    .scanIn(scanIn), .scanOut(scanOut), .shiftSel(shiftSel),
    .drClockEn(drClockEn), .updateEn(updateEn), .testMode(testMode)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, clock once, return at next negedge
  task automatic step(input logic r, input logic [N-1:0] ci, input logic si,
                      input logic sh, input logic dr, input logic up, input logic tm);
    logic [N-1:0] oldA;
    rst = r; coreIn = ci; scanIn = si; shiftSel = sh;
    drClockEn = dr; updateEn = up; testMode = tm;
    @(posedge clk);
    oldA = mA;
    if (r) begin
      mA = '0; mB = '0;
    end else begin
      if (dr) mA = sh ? {oldA[N-2:0], si} : ci;
      if (up) mB = oldA;
    end
    @(negedge clk);
  endtask

  task automatic chkPorts(input string tag);
    chk({tag, " padOut"}, padOut, testMode ? mB : coreIn);
    chk({tag, " scanOut"}, {{(N-1){1'b0}}, scanOut}, {{(N-1){1'b0}}, mA[N-1]});
  endtask

  task automatic loadPattern(input logic [N-1:0] pat, input logic tm);
    for (int k = N - 1; k >= 0; k--) begin
      step(0, 8'h3c, pat[k], 1, 1, 0, tm);
      chkPorts("R3 R6 R8 shift");
    end
  endtask

  task automatic tReset();
    step(1, '0, 0, 0, 0, 0, 0);
    step(1, 8'h5a, 0, 0, 0, 0, 0);
    chk("R1 reset passthru", padOut, 8'h5a);
    testMode = 1'b1; #0.1;
    chk("R9 reset hold", padOut, 8'h00);
    chk("R9 reset scanOut", {7'b0, scanOut}, 8'h00);
  endtask

  task automatic tPassThru();
    step(0, 8'hff, 0, 0, 0, 1, 1);
    for (int k = 0; k < 4; k++) begin
      logic [N-1:0] v;
      v = (k == 0) ? 8'h00 : (k == 1) ? 8'ha5 : (k == 2) ? 8'h81 : 8'hff;
      step(0, v, 1, 1, 0, 0, 0);
      chk("R1 passthru", padOut, v);
    end
  endtask

  task automatic tShiftUpdate(input logic [N-1:0] pat);
    loadPattern(pat, 1);
    chk("R6 pads steady after shift", padOut, mB);
    step(0, 8'h00, 0, 0, 0, 1, 1);
    chk("R2 R6 update drives pattern", padOut, pat);
  endtask

  task automatic tCapture(input logic [N-1:0] v);
    step(0, v, 1, 0, 1, 0, 1);
    chkPorts("R4 capture");
    for (int k = 0; k < N; k++) begin
      chk("R4 R8 captured bit out", {7'b0, scanOut}, {7'b0, v[N-1-k]});
      step(0, 8'h00, 0, 1, 1, 0, 1);
    end
  endtask

  task automatic tIdle();
    loadPattern(8'hc3, 1);
    for (int k = 0; k < 3; k++) begin
      step(0, 8'h5a, k[0], k[0], 0, 0, 1);
      chkPorts("R5 idle");
    end
    step(0, 8'h00, 0, 0, 0, 1, 1);
    chk("R5 contents kept", padOut, 8'hc3);
  endtask

  task automatic tSameEdge();
    loadPattern(8'h96, 1);
    step(0, 8'h00, 1, 1, 1, 1, 1);
    chk("R7 update with shift", padOut, 8'h96);
    chkPorts("R7 shift side");
    loadPattern(8'h0f, 1);
    step(0, 8'he7, 0, 0, 1, 1, 1);
    chk("R7 update with capture", padOut, 8'h0f);
    step(0, 8'h00, 0, 0, 0, 1, 1);
    chk("R7 capture reached sample", padOut, 8'he7);
  endtask

  task automatic tMidReset();
    loadPattern(8'h7e, 1);
    step(0, 8'h00, 0, 0, 0, 1, 1);
    step(1, 8'h00, 0, 0, 0, 0, 1);
    chk("R9 hold cleared", padOut, 8'h00);
    chk("R9 sample cleared", {7'b0, scanOut}, 8'h00);
    step(0, 8'h00, 0, 0, 0, 1, 1);
    chk("R9 sample cleared via update", padOut, 8'h00);
  endtask

  initial begin
    @(negedge clk);
    tReset();
    tPassThru();
    tShiftUpdate(8'hb4);
    tShiftUpdate(8'h01);
    tCapture(8'hd2);
    tIdle();
    tSameEdge();
    tMidReset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule